// File: doc/BRIEF.md
# Disk Controller Auto Powerdown Sequencer

This block decides when the core of a disk controller may enter its low-power state and when it has to leave it. It watches the controller's idle indicators: the drive motor enables, the main status byte, the interrupt line and the head-unload timer. It also watches bus accesses to a few decoded registers and the three reset sources. From these it drives one powerdown level, which the surrounding clock-gating logic uses. A second output is a one-cycle wake-type code. It tells the core whether to run its normal reset sequence or to carry on as if it had never slept.

Auto powerdown needs two things: all four idle conditions must hold together, and an idle timer must have run out. By default the timer counts `TICKS_10MS` cycles, which is 10 ms at 100 MHz. The timer only counts while the block is armed and the other three conditions hold. Any break in them returns it to zero, so the period always covers one continuous idle stretch. A direct powerdown request takes priority over auto powerdown, and only a reset source ends it. After any wake the timer starts again from zero, and the block sleeps again once the idle period has passed.

The sequencer has four states. `ST_WAKE_OFF` is awake with auto powerdown disabled. `ST_ARMED` is awake with the timer allowed to run. `ST_AUTO_DOWN` is powered down by the idle rule. `ST_DIRECT_DOWN` is powered down on request. The transitions are:
- enable: `ST_WAKE_OFF` to `ST_ARMED`
- disable: `ST_ARMED` to `ST_WAKE_OFF`
- idle expiry: `ST_ARMED` to `ST_AUTO_DOWN`
- resume: `ST_AUTO_DOWN` to the awake state
- reset wake: either down state to the awake state
- disable exit: `ST_AUTO_DOWN` to `ST_WAKE_OFF`
- direct entry: from any state except `ST_DIRECT_DOWN`

Here "the awake state" means `ST_ARMED` when enabled and `ST_WAKE_OFF` otherwise. A reset source that arrives while the block is awake also takes this "reset wake" path, but it raises no wake code.

Top module: `fdc_autopd_seq`

## Requirements
- R1: After `rst_n` is released, `pd_out` is 0, `wake_type` is 00 and `timer_done` is 0.
- R2: Armed with all idle inputs true, the timer counts one per cycle up to `TICKS_10MS`. `pd_out` rises `TICKS_10MS+1` clock edges after the idle inputs become true, or `TICKS_10MS+2` edges after `auto_pd_en` rises with the inputs already idle.
- R3: Auto powerdown needs all of the following: `motor_en` all zero, `msr` exactly 0x80, `hut_expired` high, and the idle timer expired. Any other `msr` value, any motor bit set, or `hut_expired` low keeps `pd_out` at 0.
- R4: While `fdc_int` is high, the block does not power down, even with `msr` at 0x80.
- R5: Any cycle in which an idle input is false sends the timer back to zero. The full `TICKS_10MS+1` edges are then needed again after the inputs return to idle.
- R6: With `auto_pd_en` low the block stays awake. If `auto_pd_en` falls while auto powerdown is in effect, `pd_out` drops in that same cycle and `wake_type` shows 10.
- R7: In either powered-down state, a high `hw_reset`, `dor_srst` or `dsr_srst` drops `pd_out` in that same cycle and shows `wake_type` 01.
- R8: During auto powerdown, three accesses wake the block: a write to the digital output register whose data has any motor bit set (bits [7:4] by default, one per drive), a read of the status register, or any read or write of the data register. `pd_out` drops in that cycle, `wake_type` shows 10, and powerdown returns `TICKS_10MS+1` edges later.
- R9: A read of the digital output register, or a write to it with all motor bits clear, does not wake the block: `pd_out` stays 1 and `wake_type` stays 00.
- R10: A one-cycle `direct_pd_req` raises `pd_out` at the next edge, from the armed state or from auto powerdown. Transparent accesses do not end direct powerdown; only a reset source does. After that, auto powerdown works again.
- R11: `wake_type` is 00 in every cycle except the single cycle of a wake. It is never 11, and the cycle after a wake finds the block awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| auto_pd_en | input | 1 | Auto powerdown enable (configuration bit 0) |
| direct_pd_req | input | 1 | One-cycle direct powerdown request from the data rate register |
| motor_en | input | NUM_DRV | Current motor enable bits of the digital output register |
| msr | input | DW | Current main status register value |
| fdc_int | input | 1 | Controller interrupt line |
| hut_expired | input | 1 | Head-unload timer has expired |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| sel_dor | input | 1 | Digital output register selected |
| sel_msr | input | 1 | Main status register selected |
| sel_data | input | 1 | Data register selected |
| wdata | input | DW | Bus write data |
| hw_reset | input | 1 | Hardware reset pin |
| dor_srst | input | 1 | Software reset written through the digital output register |
| dsr_srst | input | 1 | Software reset written through the data rate register |
| pd_out | output | 1 | Powerdown level to the clock gating |
| wake_type | output | 2 | Wake code: 01 reset wake, 10 transparent resume, 00 none |
| timer_run | output | 1 | Idle timer counting |
| timer_done | output | 1 | Idle timer expired |

## Verification
If the state register held a wrong value, `pd_out` would be wrong in the very same cycle. It would also make `wake_type` pulse at the wrong time, since both outputs decode the state directly. A timer that miscounts, or that fails to clear, shows up as a powerdown edge that comes earlier or later than `TICKS_10MS+1`, so the bench measures that latency exactly after every kind of wake. A wrong decode of the wake sources shows up as `pd_out` staying high, or as the wrong wake code, during the access cycle itself. The bench therefore samples within that cycle.

// File: rtl/apd_pkg.sv
package apd_pkg;

    typedef enum logic [1:0] {
        ST_WAKE_OFF    = 2'd0,
        ST_ARMED       = 2'd1,
        ST_AUTO_DOWN   = 2'd2,
        ST_DIRECT_DOWN = 2'd3
    } apd_state_e;

    typedef enum logic [1:0] {
        WK_NONE   = 2'b00,
        WK_RESET  = 2'b01,
        WK_RESUME = 2'b10
    } wake_e;

endpackage

// File: rtl/apd_idle_check.sv
module apd_idle_check #(
    parameter int              NUM_DRV  = 4,
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   MSR_IDLE = 8'h80
) (
    input  logic [NUM_DRV-1:0] motor_en,
    input  logic [DW-1:0]      msr,
    input  logic               fdc_int,
    input  logic               hut_expired,
    output logic               idle_ok
);

    logic motors_off;
    logic status_quiet;

    always_comb begin
        motors_off   = (motor_en == '0);
        status_quiet = (msr == MSR_IDLE) && !fdc_int;
        idle_ok      = motors_off && status_quiet && hut_expired;
    end

endmodule

// File: rtl/apd_wake_decode.sv
module apd_wake_decode #(
    parameter int NUM_DRV   = 4,
    parameter int MOTOR_LSB = 4,
    parameter int DW        = 8
) (
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          sel_dor,
    input  logic          sel_msr,
    input  logic          sel_data,
    input  logic [DW-1:0] wdata,
    input  logic          hw_reset,
    input  logic          dor_srst,
    input  logic          dsr_srst,
    output logic          rst_hit,
    output logic          resume_hit
);

    logic [NUM_DRV-1:0] motor_set;

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_motor
        assign motor_set[d] = wdata[MOTOR_LSB + d];
    end

    logic dor_motor_wr;
    logic msr_read;
    logic data_touch;

    always_comb begin
        dor_motor_wr = bus_wr && sel_dor && (motor_set != '0);
        msr_read     = bus_rd && sel_msr;
        data_touch   = (bus_rd || bus_wr) && sel_data;
        resume_hit   = dor_motor_wr || msr_read || data_touch;
        rst_hit      = hw_reset || dor_srst || dsr_srst;
    end

endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
    parameter int TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done,
    output logic running
);

    localparam int            CW   = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        done    = (cnt_q == LAST);
        running = run && !done;
    end

    // R2: the count never passes the limit
    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: a running count advances by exactly one
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: a broken idle stretch leaves the counter at zero
    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/fdc_autopd_seq.sv
module fdc_autopd_seq
    import apd_pkg::*;
#(
    parameter int TICKS_10MS = 1_000_000,
    parameter int NUM_DRV    = 4,
    parameter int MOTOR_LSB  = 4,
    parameter int DW         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_pd_en,
    input  logic               direct_pd_req,
    input  logic [NUM_DRV-1:0] motor_en,
    input  logic [DW-1:0]      msr,
    input  logic               fdc_int,
    input  logic               hut_expired,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               sel_dor,
    input  logic               sel_msr,
    input  logic               sel_data,
    input  logic [DW-1:0]      wdata,
    input  logic               hw_reset,
    input  logic               dor_srst,
    input  logic               dsr_srst,
    output logic               pd_out,
    output logic [1:0]         wake_type,
    output logic               timer_run,
    output logic               timer_done
);

    localparam int MOTOR_TOP = MOTOR_LSB + NUM_DRV;

    initial begin
        if (MOTOR_TOP > DW) $error("motor field does not fit in the data width");
    end

    logic       idle_ok;
    logic       rst_hit;
    logic       resume_hit;
    logic       tmr_run;
    logic       tmr_done;
    logic       tmr_running;

    apd_state_e state_q;
    apd_state_e state_d;
    apd_state_e awake_tgt;
    wake_e      wake_d;

    apd_idle_check #(
        .NUM_DRV (NUM_DRV),
        .DW      (DW),
        .MSR_IDLE(DW'(8'h80))
    ) u_idle (
        .motor_en   (motor_en),
        .msr        (msr),
        .fdc_int    (fdc_int),
        .hut_expired(hut_expired),
        .idle_ok    (idle_ok)
    );

    apd_wake_decode #(
        .NUM_DRV  (NUM_DRV),
        .MOTOR_LSB(MOTOR_LSB),
        .DW       (DW)
    ) u_wake (
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .sel_dor   (sel_dor),
        .sel_msr   (sel_msr),
        .sel_data  (sel_data),
        .wdata     (wdata),
        .hw_reset  (hw_reset),
        .dor_srst  (dor_srst),
        .dsr_srst  (dsr_srst),
        .rst_hit   (rst_hit),
        .resume_hit(resume_hit)
    );

    apd_idle_timer #(
        .TICKS(TICKS_10MS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .done   (tmr_done),
        .running(tmr_running)
    );

    // next state and wake code
    always_comb begin
        awake_tgt = auto_pd_en ? ST_ARMED : ST_WAKE_OFF;
        state_d   = state_q;
        wake_d    = WK_NONE;
        unique case (state_q)
            ST_WAKE_OFF: begin
                if (rst_hit)            state_d = awake_tgt;
                else if (direct_pd_req) state_d = ST_DIRECT_DOWN;
                else if (auto_pd_en)    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (rst_hit)                   state_d = awake_tgt;
                else if (direct_pd_req)        state_d = ST_DIRECT_DOWN;
                else if (!auto_pd_en)          state_d = ST_WAKE_OFF;
                else if (idle_ok && tmr_done)  state_d = ST_AUTO_DOWN;
            end
            ST_AUTO_DOWN: begin
                if (rst_hit) begin
                    state_d = awake_tgt;
                    wake_d  = WK_RESET;
                end else if (direct_pd_req) begin
                    state_d = ST_DIRECT_DOWN;
                end else if (resume_hit) begin
                    state_d = awake_tgt;
                    wake_d  = WK_RESUME;
                end else if (!auto_pd_en) begin
                    state_d = ST_WAKE_OFF;
                    wake_d  = WK_RESUME;
                end
            end
            ST_DIRECT_DOWN: begin
                if (rst_hit) begin
                    state_d = awake_tgt;
                    wake_d  = WK_RESET;
                end
            end
            default: state_d = ST_WAKE_OFF;
        endcase
        tmr_run = (state_q == ST_ARMED) && (state_d == ST_ARMED) && idle_ok && !rst_hit;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAKE_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pd_out     = ((state_q == ST_AUTO_DOWN) || (state_q == ST_DIRECT_DOWN))
                     && (wake_d == WK_NONE);
        wake_type  = wake_d;
        timer_run  = tmr_running;
        timer_done = tmr_done;
    end

    // R3: auto powerdown is only entered from a fully idle, expired stretch
    assert_enter_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AUTO_DOWN && $past(state_q) == ST_ARMED) |-> $past(idle_ok && tmr_done));

    // R4: a raised interrupt blocks entry into auto powerdown
    assert_int_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && fdc_int && !direct_pd_req) |=> (state_q != ST_AUTO_DOWN));

    // R10: direct powerdown is left only through a reset source
    assert_direct_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIRECT_DOWN && !rst_hit) |=> (state_q == ST_DIRECT_DOWN));

    // R11: never both wake codes at once
    assert_wake_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_type));

    // R11: the cycle after a wake finds the block awake
    assert_wake_lands_awake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_type != 2'b00) |=> (state_q == ST_ARMED || state_q == ST_WAKE_OFF));

    // R7: a wake code never coincides with the powerdown level
    assert_pd_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_type != 2'b00) |-> !pd_out);

endmodule

// File: tb/test_fdc_autopd_seq.sv
`timescale 1ns/100ps
module test_fdc_autopd_seq;

    localparam int TK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_pd_en = 1'b0;
    logic       direct_pd_req = 1'b0;
    logic [3:0] motor_en = '0;
    logic [7:0] msr = 8'h80;
    logic       fdc_int = 1'b0;
    logic       hut_expired = 1'b1;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       sel_dor = 1'b0;
    logic       sel_msr = 1'b0;
    logic       sel_data = 1'b0;
    logic [7:0] wdata = '0;
    logic       hw_reset = 1'b0;
    logic       dor_srst = 1'b0;
    logic       dsr_srst = 1'b0;
    logic       pd_out;
    logic [1:0] wake_type;
    logic       timer_run;
    logic       timer_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fdc_autopd_seq #(.TICKS_10MS(TK)) i_fdc_autopd_seq (
        .clk(clk), .rst_n(rst_n), .auto_pd_en(auto_pd_en), .direct_pd_req(direct_pd_req),
        .motor_en(motor_en), .msr(msr), .fdc_int(fdc_int), .hut_expired(hut_expired),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .sel_dor(sel_dor), .sel_msr(sel_msr),
        .sel_data(sel_data), .wdata(wdata), .hw_reset(hw_reset), .dor_srst(dor_srst),
        .dsr_srst(dsr_srst), .pd_out(pd_out), .wake_type(wake_type),
        .timer_run(timer_run), .timer_done(timer_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    // counts clock edges until powerdown shows, capped
    task automatic measure(output int n);
        n = 0;
        while (!pd_out && n < 100) begin
            cyc();
            n++;
        end
    endtask

    task automatic acc_set(input int k);
        case (k)
            0: begin bus_rd = 1; sel_dor = 1; end
            1: begin bus_wr = 1; sel_dor = 1; wdata = 8'h0C; end
            2, 3, 4, 5: begin bus_wr = 1; sel_dor = 1; wdata = 8'(1 << (k + 2)); end
            6: begin bus_rd = 1; sel_msr = 1; end
            7: begin bus_rd = 1; sel_data = 1; end
            default: begin bus_wr = 1; sel_data = 1; wdata = 8'h5A; end
        endcase
    endtask

    task automatic acc_clr();
        bus_rd = 0; bus_wr = 0; sel_dor = 0; sel_msr = 0; sel_data = 0; wdata = '0;
    endtask

    task automatic get_down();
        int n;
        measure(n);
    endtask

    task automatic wake_data();
        acc_set(7);
        cyc();
        acc_clr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 pd", int'(pd_out), 0);
        chk("R1 wake", int'(wake_type), 0);
        chk("R1 done", int'(timer_done), 0);

        // R6 disabled: never sleeps
        repeat (3 * TK) cyc();
        chk("R6 disabled pd", int'(pd_out), 0);

        // R2 enable latency
        auto_pd_en = 1'b1;
        measure(n);
        chk("R2 enable latency", n, TK + 2);

        // R8 / R9 / R11 access sweep
        for (int k = 0; k < 9; k++) begin
            bit wakes;
            wakes = (k >= 2);
            get_down();
            acc_set(k);
            #0.2;
            if (wakes) begin
                chk("R8 pd drop", int'(pd_out), 0);
                chk("R8 resume code", int'(wake_type), 2);
            end else begin
                chk("R9 pd held", int'(pd_out), 1);
                chk("R9 no code", int'(wake_type), 0);
            end
            cyc();
            acc_clr();
            #0.2;
            chk("R11 code cleared", int'(wake_type), 0);
            if (wakes) begin
                measure(n);
                chk("R8 re-sleep latency", n, TK + 1);
            end else begin
                chk("R9 still down", int'(pd_out), 1);
            end
        end

        // R3 status sweep
        for (int v = 0; v < 256; v++) begin
            msr = 8'(v);
            acc_set(7);
            cyc();
            acc_clr();
            repeat (TK + 3) cyc();
            chk("R3 msr sweep", int'(pd_out), (v == 8'h80) ? 1 : 0);
        end
        msr = 8'h80;

        // R3 motor bits and head unload
        for (int j = 0; j < 4; j++) begin
            get_down();
            motor_en = 4'(1 << j);
            wake_data();
            repeat (3 * TK) cyc();
            chk("R3 motor blocks", int'(pd_out), 0);
            motor_en = '0;
        end
        hut_expired = 1'b0;
        repeat (3 * TK) cyc();
        chk("R3 hut blocks", int'(pd_out), 0);
        hut_expired = 1'b1;
        measure(n);
        chk("R3 hut release latency", n, TK + 1);

        // R4 interrupt with idle status
        fdc_int = 1'b1;
        wake_data();
        repeat (3 * TK) cyc();
        chk("R4 int blocks", int'(pd_out), 0);
        fdc_int = 1'b0;
        measure(n);
        chk("R4 release latency", n, TK + 1);

        // R5 restart after a one-cycle break
        wake_data();
        repeat (TK - 2) cyc();
        fdc_int = 1'b1;
        cyc();
        fdc_int = 1'b0;
        measure(n);
        chk("R5 restart latency", n, TK + 1);

        // R6 disable while down
        auto_pd_en = 1'b0;
        #0.2;
        chk("R6 pd drop", int'(pd_out), 0);
        chk("R6 resume code", int'(wake_type), 2);
        cyc();
        chk("R6 stays awake", int'(pd_out), 0);
        chk("R11 single pulse", int'(wake_type), 0);
        auto_pd_en = 1'b1;
        measure(n);
        chk("R6 re-enable latency", n, TK + 2);

        // R7 reset sources from auto powerdown
        for (int s = 0; s < 3; s++) begin
            get_down();
            if (s == 0) hw_reset = 1'b1; else if (s == 1) dor_srst = 1'b1; else dsr_srst = 1'b1;
            #0.2;
            chk("R7 pd drop", int'(pd_out), 0);
            chk("R7 reset code", int'(wake_type), 1);
            cyc();
            hw_reset = 0; dor_srst = 0; dsr_srst = 0;
            measure(n);
            chk("R7 re-sleep latency", n, TK + 1);
        end

        // R10 direct powerdown from armed
        wake_data();
        cyc();
        direct_pd_req = 1'b1;
        #0.2;
        chk("R10 not yet", int'(pd_out), 0);
        cyc();
        direct_pd_req = 1'b0;
        #0.2;
        chk("R10 direct pd", int'(pd_out), 1);
        for (int k = 6; k < 9; k++) begin
            acc_set(k);
            #0.2;
            chk("R10 access ignored", int'(pd_out), 1);
            chk("R10 no code", int'(wake_type), 0);
            cyc();
            acc_clr();
        end
        repeat (3 * TK) cyc();
        chk("R10 holds", int'(pd_out), 1);
        dsr_srst = 1'b1;
        #0.2;
        chk("R10 reset wake code", int'(wake_type), 1);
        cyc();
        dsr_srst = 1'b0;
        measure(n);
        chk("R10 auto again", n, TK + 1);

        // R10 direct overrides auto powerdown
        direct_pd_req = 1'b1;
        cyc();
        direct_pd_req = 1'b0;
        acc_set(6);
        #0.2;
        chk("R10 override pd", int'(pd_out), 1);
        chk("R10 override no code", int'(wake_type), 0);
        cyc();
        acc_clr();
        hw_reset = 1'b1;
        #0.2;
        chk("R10 override exit", int'(pd_out), 0);
        cyc();
        hw_reset = 1'b0;
        #0.2;
        chk("R11 code idle", int'(wake_type), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule